// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer Bank

This block holds six identical up-counting timers behind a simple 32-bit register bus. Software programs a period, a clock divisor and a mode for each channel. Once a channel is started, its count climbs from zero once every divisor cycles of the block clock. When the count reaches the period, the channel latches a pending flag. A periodic channel then restarts from zero. A one-shot channel freezes and turns itself off.

Each channel drives its own interrupt line. The line is high while the channel's pending flag and its interrupt enable are both set. Software clears the flag by writing a one to it. The running count can be read at any time, which lets one channel serve as a free-running time base while another produces timed events.

Reads are registered: the read data appears on the clock edge that samples the read strobe and holds until the next read. Writes take effect on the edge that samples the write strobe.

Top module: `tmr_bank`

## Requirements
- R1: Channel n occupies byte offsets n*0x10 to n*0x10+0xF, with the period register at +0x0, the count at +0x4, control at +0x8 and interrupt status/enable at +0xC. The channels are independent. An address whose channel index is 6 or more reads as zero and ignores writes.
- R2: After reset, every register reads zero and every interrupt line is low.
- R3: The period register stores bits [27:0] of the written word, and bits [31:28] read as zero. The count register likewise reads only 28 significant bits.
- R4: In the control word, bit 28 is run, bit 24 is mode (1 periodic, 0 one-shot) and bits [15:0] are the divisor. All other bits read as zero. A write that takes run from 0 to 1 clears the count and the divisor phase.
- R5: While running, the count rises by one every D cycles, where D is the divisor field. Values 0 and 1 are handled as 2.
- R6: With period T and divisor D, the pending flag sets on the T*D-th clock edge after the starting write. In periodic mode the count returns to zero on that edge and the next expiry follows T*D edges later.
- R7: In one-shot mode, expiry leaves the count equal to the period and clears the run bit.
- R8: Interrupt register bit 16 is pending. Writing 1 there clears it, and writing 0 leaves it unchanged. Bit 20 is the interrupt enable. All other bits read as zero.
- R9: A channel's interrupt output is high exactly when both its pending and enable bits are set, and it changes on the same edge as those bits.
- R10: Writes to the count register have no effect.
- R11: When an expiry and a clearing write to pending fall on the same edge, pending ends up set.
- R12: Writing zero to the control word stops the channel, and its count then stays frozen.
- R13: Read data updates only on an edge where the read strobe is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 6 | One interrupt line per channel |

## Verification
Two events can land on the same clock edge: a channel's expiry, which sets pending, and a software write of one to pending, which clears it. The bench runs a periodic channel with a short period, counts edges from the starting write, and issues the clearing write so that it is sampled on the exact edge of the second expiry. It then reads back the interrupt register and expects pending to still be set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 28;
  localparam int DIV_W    = 16;
  localparam int RUN_BIT  = 28;
  localparam int MODE_BIT = 24;
  localparam int PEND_BIT = 16;
  localparam int IE_BIT   = 20;
  localparam int MIN_DIV  = 2;
  localparam int WIN_LSB  = 4;   // 16-byte window per channel

  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_COUNT  = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_INT    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_DIV);

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] last_phase;

  always_comb begin
    eff_div    = (div < FLOOR) ? FLOOR : div;
    last_phase = eff_div - DIV_W'(1);
    tick       = run && (phase_q >= last_phase);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !run || tick) phase_q <= '0;
    else                              phase_q <= phase_q + DIV_W'(1);
  end
endmodule

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input  logic                 wr,
  input  logic [ADDR_W-1:2]    word_addr,
  output logic [NCH-1:0]       wr_period,
  output logic [NCH-1:0]       wr_count,
  output logic [NCH-1:0]       wr_ctrl,
  output logic [NCH-1:0]       wr_int,
  output logic [NCH-1:0]       ch_hit,
  output tmr_pkg::reg_sel_e    sel
);
  localparam int CH_W = ADDR_W - tmr_pkg::WIN_LSB;

  logic [CH_W-1:0] ch_idx;

  assign ch_idx = word_addr[ADDR_W-1:tmr_pkg::WIN_LSB];
  assign sel    = tmr_pkg::reg_sel_e'(word_addr[tmr_pkg::WIN_LSB-1:2]);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign ch_hit[c]    = (ch_idx == CH_W'(c));
    assign wr_period[c] = wr && ch_hit[c] && (sel == tmr_pkg::SEL_PERIOD);
    assign wr_count[c]  = wr && ch_hit[c] && (sel == tmr_pkg::SEL_COUNT);
    assign wr_ctrl[c]   = wr && ch_hit[c] && (sel == tmr_pkg::SEL_CTRL);
    assign wr_int[c]    = wr && ch_hit[c] && (sel == tmr_pkg::SEL_INT);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W   = 28,
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_period,
  input  logic             wr_ctrl,
  input  logic             wr_int,
  input  logic [CNT_W-1:0] wd_period,
  input  logic             wd_run,
  input  logic             wd_mode,
  input  logic [DIV_W-1:0] wd_div,
  input  logic             wd_clr,
  input  logic             wd_ie,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             mode_q,
  output logic [DIV_W-1:0] div_q,
  output logic             pend_q,
  output logic             ie_q,
  output logic             irq_q,
  output logic             expire,
  output logic             start
);
  logic             tick;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             pend_d;
  logic             ie_d;

  assign start = wr_ctrl && wd_run && !run_q;

  tmr_prescaler #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .run   (run_q),
    .clear (start),
    .div   (div_q),
    .tick  (tick)
  );

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
    expire  = tick && (cnt_inc >= {1'b0, period_q});

    cnt_d = cnt_q;
    if (start)             cnt_d = '0;
    else if (expire)       cnt_d = mode_q ? '0 : period_q;
    else if (tick)         cnt_d = cnt_inc[CNT_W-1:0];

    run_d = run_q;
    if (wr_ctrl)                 run_d = wd_run;
    else if (expire && !mode_q)  run_d = 1'b0;

    pend_d = pend_q;
    if (expire)                  pend_d = 1'b1;
    else if (wr_int && wd_clr)   pend_d = 1'b0;

    ie_d = wr_int ? wd_ie : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      cnt_q    <= '0;
      run_q    <= 1'b0;
      mode_q   <= 1'b0;
      div_q    <= '0;
      pend_q   <= 1'b0;
      ie_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_period) period_q <= wd_period;
      if (wr_ctrl) begin
        mode_q <= wd_mode;
        div_q  <= wd_div;
      end
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      ie_q   <= ie_d;
      irq_q  <= pend_d && ie_d;
    end
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [tmr_pkg::DATA_W-1:0]  bus_wdata,
  output logic [tmr_pkg::DATA_W-1:0]  bus_rdata,
  output logic [NCH-1:0]              irq
);
  import tmr_pkg::*;

  logic [NCH-1:0]   wr_period_v, wr_count_v, wr_ctrl_v, wr_int_v, ch_hit_v;
  reg_sel_e         sel;
  logic [CNT_W-1:0] period_v [NCH];
  logic [CNT_W-1:0] cnt_v    [NCH];
  logic [DIV_W-1:0] div_v    [NCH];
  logic [NCH-1:0]   run_v, mode_v, pend_v, ie_v, expire_v, start_v;
  logic [DATA_W-1:0] rd_word;
  logic             unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CNT_W+1]};

  tmr_bus_dec #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .wr        (bus_wr),
    .word_addr (bus_addr[ADDR_W-1:2]),
    .wr_period (wr_period_v),
    .wr_count  (wr_count_v),
    .wr_ctrl   (wr_ctrl_v),
    .wr_int    (wr_int_v),
    .ch_hit    (ch_hit_v),
    .sel       (sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_period (wr_period_v[c]),
      .wr_ctrl   (wr_ctrl_v[c]),
      .wr_int    (wr_int_v[c]),
      .wd_period (bus_wdata[CNT_W-1:0]),
      .wd_run    (bus_wdata[RUN_BIT]),
      .wd_mode   (bus_wdata[MODE_BIT]),
      .wd_div    (bus_wdata[DIV_W-1:0]),
      .wd_clr    (bus_wdata[PEND_BIT]),
      .wd_ie     (bus_wdata[IE_BIT]),
      .period_q  (period_v[c]),
      .cnt_q     (cnt_v[c]),
      .run_q     (run_v[c]),
      .mode_q    (mode_v[c]),
      .div_q     (div_v[c]),
      .pend_q    (pend_v[c]),
      .ie_q      (ie_v[c]),
      .irq_q     (irq[c]),
      .expire    (expire_v[c]),
      .start     (start_v[c])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ch_hit_v[c]) begin
        unique case (sel)
          SEL_PERIOD: rd_word[CNT_W-1:0] = period_v[c];
          SEL_COUNT:  rd_word[CNT_W-1:0] = cnt_v[c];
          SEL_CTRL: begin
            rd_word[RUN_BIT]   = run_v[c];
            rd_word[MODE_BIT]  = mode_v[c];
            rd_word[DIV_W-1:0] = div_v[c];
          end
          SEL_INT: begin
            rd_word[PEND_BIT] = pend_v[c];
            rd_word[IE_BIT]   = ie_v[c];
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int NCH   = 6,
  parameter int CNT_W = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rd,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NCH-1:0]   irq,
  input logic [NCH-1:0]   wr_count_v,
  input logic [NCH-1:0]   wr_ctrl_v,
  input logic [NCH-1:0]   wr_int_v,
  input logic [CNT_W-1:0] cnt_v [NCH],
  input logic [NCH-1:0]   run_v,
  input logic [NCH-1:0]   mode_v,
  input logic [NCH-1:0]   pend_v,
  input logic [NCH-1:0]   ie_v,
  input logic [NCH-1:0]   expire_v
);
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)) else $error("rdata moved without read"); // R13

  for (genvar c = 0; c < NCH; c++) begin : g_ast
    AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
      $rose(run_v[c]) |-> (cnt_v[c] == '0)) else $error("start count"); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      (run_v[c] && $past(run_v[c]) && !$past(expire_v[c]))
      |-> (cnt_v[c] == $past(cnt_v[c]) || cnt_v[c] == $past(cnt_v[c]) + CNT_W'(1)))
      else $error("count step"); // R5

    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (rst)
      (expire_v[c] && !mode_v[c] && !wr_ctrl_v[c]) |=> !run_v[c])
      else $error("one-shot did not stop"); // R7

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (rst)
      (pend_v[c] && !(wr_int_v[c] && bus_wdata[16])) |=> pend_v[c])
      else $error("pending dropped"); // R8

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[c]) |-> (pend_v[c] && ie_v[c])) else $error("irq gate"); // R9

    AST_COUNT_RO: assert property (@(posedge clk) disable iff (rst)
      (wr_count_v[c] && !run_v[c] && !wr_ctrl_v[c]) |=> $stable(cnt_v[c]))
      else $error("count written"); // R10

    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (rst)
      expire_v[c] |=> pend_v[c]) else $error("expiry lost"); // R11
  end
endmodule

bind tmr_bank tmr_bank_chk #(.NCH(NCH), .CNT_W(tmr_pkg::CNT_W)) u_chk (.*);

// File: tb/tmr_bank_tb_top.sv
module tmr_bank_tb_top;
  localparam int NCH = 6;
  localparam int NV  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_bank #(.NCH(NCH), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // {is_read, addr, data, expected, requirement number}
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0, 8'd3},        // R3 period upper bits dropped
    {1'b1, 8'h00, 32'h0, 32'h0FFF_FFFF, 8'd3},        // R3
    {1'b0, 8'h28, 32'h3300_0005, 32'h0, 8'd4},        // R4 reserved control bits
    {1'b1, 8'h28, 32'h0, 32'h1100_0005, 8'd4},        // R4
    {1'b0, 8'h28, 32'h0, 32'h0, 8'd12},               // R12 stop
    {1'b1, 8'h28, 32'h0, 32'h0, 8'd12},               // R12
    {1'b0, 8'h5C, 32'hFFFF_FFFF, 32'h0, 8'd8},        // R8 reserved int bits
    {1'b1, 8'h5C, 32'h0, 32'h0010_0000, 8'd8},        // R8
    {1'b0, 8'h5C, 32'h0, 32'h0, 8'd8},                // R8
    {1'b0, 8'h34, 32'h0000_0123, 32'h0, 8'd10},       // R10 count write
    {1'b1, 8'h34, 32'h0, 32'h0, 8'd10},               // R10
    {1'b0, 8'h40, 32'h0000_0ABC, 32'h0, 8'd1},        // R1 channel 4 period
    {1'b1, 8'h40, 32'h0, 32'h0000_0ABC, 8'd1},        // R1
    {1'b0, 8'h60, 32'h1234_5678, 32'h0, 8'd1},        // R1 unmapped channel
    {1'b1, 8'h60, 32'h0, 32'h0, 8'd1},                // R1
    {1'b1, 8'h10, 32'h0, 32'h0, 8'd1}                 // R1 neighbour untouched
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(input int ch, output int n);
    n = 0;
    while (!irq[ch] && n < 200) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv, rv2;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check(irq == '0, "R2 irq after reset", 32'(irq), 0);
    bus_read(8'h08, rv);
    check(rv == 0, "R2 control after reset", rv, 0);
    bus_read(8'h1C, rv);
    check(rv == 0, "R2 int after reset", rv, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) begin
        bus_read(VEC[i][79:72], rv);
        check(rv == VEC[i][39:8], $sformatf("R%0d vector %0d", VEC[i][7:0], i),
              rv, VEC[i][39:8]);
      end else begin
        bus_write(VEC[i][79:72], VEC[i][71:40]);
      end
    end

    // R13 read data holds without read strobe
    bus_read(8'h40, rv);
    repeat (3) @(negedge clk);
    check(bus_rdata == rv, "R13 rdata hold", bus_rdata, rv);

    // R5 R6 R9 periodic channel 1: period 3, divisor 4
    bus_write(8'h10, 32'd3);
    bus_write(8'h1C, 32'h0010_0000);
    bus_write(8'h18, 32'h1100_0004);
    wait_irq(1, n);
    check(n == 12, "R6 first expiry edge", n, 12);
    check(irq == 6'b000010, "R9 only channel 1 irq", 32'(irq), 32'h2);
    bus_write(8'h1C, 32'h0011_0000);
    check(irq[1] == 1'b0, "R8 clear drops irq", 32'(irq[1]), 0);
    wait_irq(1, n);
    check(n == 11, "R6 periodic re-expiry", n, 11);

    // R12 stop freezes count
    bus_write(8'h18, 32'h0);
    bus_read(8'h14, rv);
    repeat (20) @(negedge clk);
    bus_read(8'h14, rv2);
    check(rv2 == rv, "R12 frozen count", rv2, rv);

    // R5 R7 one-shot channel 2: divisor 0 acts as 2, period 5, irq off
    bus_write(8'h2C, 32'h0001_0000);
    bus_write(8'h20, 32'd5);
    bus_write(8'h28, 32'h1000_0000);
    n = 0;
    begin
      logic [31:0] iv;
      iv = 0;
      while (iv[16] == 1'b0 && n < 100) begin
        bus_read(8'h2C, iv);
        n++;
      end
      // read k samples state before edge k: pending first visible when k-1 >= 10
      check(n == 11, "R5 divisor floor timing", n, 11);
      check(iv == 32'h0001_0000, "R9 pending without enable", iv, 32'h0001_0000);
    end
    check(irq[2] == 1'b0, "R9 irq masked", 32'(irq[2]), 0);
    bus_read(8'h28, rv);
    check(rv == 0, "R7 run bit self-cleared", rv, 0);
    bus_read(8'h24, rv);
    check(rv == 5, "R7 count holds period", rv, 5);
    bus_write(8'h2C, 32'h0010_0000);
    check(irq[2] == 1'b1, "R9 enable raises irq", 32'(irq[2]), 1);

    // R11 clear collides with expiry: channel 0 period 2, divisor 2
    bus_write(8'h00, 32'd2);
    bus_write(8'h0C, 32'h0010_0000);
    bus_write(8'h08, 32'h1100_0002);
    repeat (7) @(negedge clk);
    bus_write(8'h0C, 32'h0011_0000);  // sampled on the 8th edge = second expiry
    bus_read(8'h0C, rv);
    check(rv == 32'h0011_0000, "R11 expiry beats clear", rv, 32'h0011_0000);
    bus_write(8'h0C, 32'h0011_0000);
    bus_read(8'h0C, rv);
    check(rv == 32'h0010_0000, "R8 clear away from expiry", rv, 32'h0010_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule